// File: doc/BRIEF.md
# Exponent-Aligned Four-Way Significand Adder

This block is one reduction stage of a mixed-precision multiply-accumulate datapath. Each cycle it may take four products, each given as a magnitude significand, a sign bit and an unsigned exponent. It finds the largest of the four exponents and shifts every significand right by its distance from that largest exponent. It then applies each sign and adds the four aligned values into one two's complement fixed-point sum, tagged with the largest exponent. The sum and exponent are registered and come out one cycle after the input with a valid flag.

A two-bit mode input chooses between an integer mode and three floating-point modes. In integer mode all products share one exponent, supplied on its own input. Each significand lane then carries a full 16-bit two's complement product, and the stage works as a plain integer adder tree. In this mode the alignment shifters and the exponent comparison get constant zero operands, so they stay idle.

In floating-point modes each 10-bit significand is placed at the top of a 28-bit field before it is shifted. Bits shifted below the top ten are kept as fraction bits, so the output value is `out_sum * 2^(out_exp - 18)` in units of the input significand LSB.

Top module: `prod_align_add4`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_sum` and `out_exp` are zero. `out_valid` equals the `in_valid` of the previous cycle. When `in_valid` is low, `out_sum` and `out_exp` keep their previous values.
- R2: In a floating-point mode, `out_exp` is the largest of the four 8-bit unsigned lane exponents (lane i at `prod_exp[8i+7:8i]`).
- R3: In a floating-point mode, each lane's 10-bit significand is placed at bits 27:18 of a 28-bit field. The field is shifted right by (largest exponent − lane exponent), and bits that fall below bit 0 are discarded. A shift of 28 or more yields zero.
- R4: In a floating-point mode, a lane whose `prod_neg` bit is 1 contributes the negated aligned value. `out_sum` is the 32-bit two's complement sum of the four lane contributions.
- R5: In a floating-point mode, only bits 9:0 of each 16-bit lane in `prod_sig` (lane i at `prod_sig[16i+15:16i]`) are used; bits 15:10 have no effect on the output.
- R6: Mode encoding: `2'b00` is integer mode. `2'b01`, `2'b10` and `2'b11` are floating-point modes and produce identical results for identical inputs.
- R7: In integer mode, each 16-bit lane is read as a two's complement value. `out_sum` is their sum sign-extended to 32 bits and `out_exp` is `shared_exp`. The per-lane exponents and `prod_neg` have no effect.
- R8: While integer mode is selected, the alignment shifters receive constant zero operands, so their outputs stay at zero and do not toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input products are valid this cycle |
| mode | input | 2 | Precision mode (00 integer, others floating-point) |
| shared_exp | input | 8 | Common exponent used in integer mode |
| prod_sig | input | 64 | Four 16-bit significand lanes |
| prod_exp | input | 32 | Four 8-bit unsigned lane exponents |
| prod_neg | input | 4 | Per-lane sign bit (1 = negative), floating-point modes |
| out_valid | output | 1 | Registered sum is new this cycle |
| out_sum | output | 32 | Registered two's complement aligned sum |
| out_exp | output | 8 | Registered exponent of the sum |

## Verification
The hardest cases to reach from random operands are the alignment edges: a lane exactly 27 steps below the maximum, which keeps a single bit, and a lane 28 or more steps below, which vanishes. Uniform random exponents over 0..255 almost never land on those distances. The bench therefore drives directed vectors at the 27/28 boundary and the 0/255 extremes. It also draws random exponents from a narrow window around a random base, so that distances from 0 to about 31 come up often. Mode switches between integer and floating-point modes, with the unused fields filled with noise, show that the ignored inputs stay ignored.

// File: rtl/prod_align_pkg.sv
// Package: shared sizes and the mode encoding for the aligned four-way adder.
// Assumes the product count is a power of two (the reduction trees rely on it).
package prod_align_pkg;

    localparam int SIG_W  = 10;  // floating-point significand width
    localparam int EXP_W  = 8;   // unsigned exponent width
    localparam int INT_W  = 16;  // integer-mode product width (lane width)
    localparam int ACC_W  = 28;  // alignment field / adder width
    localparam int SUM_W  = 32;  // registered sum width
    localparam int N_PROD = 4;   // products per reduction

    typedef enum logic [1:0] {
        MODE_INT  = 2'b00,
        MODE_FP_A = 2'b01,
        MODE_FP_B = 2'b10,
        MODE_FP_C = 2'b11
    } prec_mode_e;

    // Decode: true when the stage should run as a plain integer tree.
    function automatic logic is_int_mode(input logic [1:0] m);
        return (m == MODE_INT);
    endfunction

endpackage

// File: rtl/prod_exp_max.sv
// Module: prod_exp_max
// Finds the largest of N unsigned exponents with a balanced compare tree.
// Assumes N is a power of two; clk/rst_n serve only the embedded checks.
module prod_exp_max #(
    parameter int N     = 4,
    parameter int EXP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N*EXP_W-1:0] exp_vec,
    output logic [EXP_W-1:0]   emax
);

    localparam int NODES = 2 * N - 1;

    logic [EXP_W-1:0] node [NODES];
    logic [N-1:0]     hit;

    // Compare tree: leaves hold inputs, each parent keeps the larger child.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            node[N-1+i] = exp_vec[i*EXP_W +: EXP_W];
        end
        for (int k = N - 2; k >= 0; k--) begin
            node[k] = (node[2*k+1] >= node[2*k+2]) ? node[2*k+1] : node[2*k+2];
        end
    end

    assign emax = node[0];

    // Per-input checks: the result bounds every input, and one input equals it.
    for (genvar g = 0; g < N; g++) begin : g_chk
        assign hit[g] = (exp_vec[g*EXP_W +: EXP_W] == emax);

        a_r2_max_bounds: assert property (@(posedge clk) disable iff (!rst_n)
            emax >= exp_vec[g*EXP_W +: EXP_W]);
    end

    a_r2_max_is_input: assert property (@(posedge clk) disable iff (!rst_n)
        hit != '0);

endmodule

// File: rtl/prod_align_lane.sv
// Module: prod_align_lane
// One product lane. In floating-point mode it puts the significand at the top
// of an ACC_W field, shifts it right by its distance from the group maximum
// exponent and applies the sign. In integer mode it sign-extends the whole
// lane and holds the shifter operands at zero.
// Assumes emax_in >= exp_in whenever floating-point mode is active.
module prod_align_lane #(
    parameter int SIG_W = 10,
    parameter int EXP_W = 8,
    parameter int INT_W = 16,
    parameter int ACC_W = 28,
    parameter int SUM_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    int_mode,
    input  logic [INT_W-1:0]        sig_in,
    input  logic                    neg_in,
    input  logic [EXP_W-1:0]        exp_in,
    input  logic [EXP_W-1:0]        emax_in,
    output logic [ACC_W-1:0]        aligned_mag,
    output logic signed [SUM_W-1:0] lane_val
);

    localparam int PAD_W = ACC_W - SIG_W;
    localparam logic [EXP_W:0] SHIFT_LIM = (EXP_W + 1)'(ACC_W);

    logic [EXP_W-1:0]        raw_diff;
    logic [SIG_W-1:0]        fp_sig;
    logic [EXP_W-1:0]        fp_diff;
    logic [ACC_W-1:0]        field;
    logic [SUM_W-1:0]        fp_ext;
    logic [SUM_W-1:0]        int_ext;

    assign raw_diff = emax_in - exp_in;

    // Operand isolation: in integer mode the shifter sees constant zeros.
    always_comb begin
        fp_sig  = int_mode ? '0 : sig_in[SIG_W-1:0];
        fp_diff = int_mode ? '0 : raw_diff;
    end

    // Alignment shifter: top-justified field, flushed to zero past its width.
    always_comb begin
        field = {fp_sig, {PAD_W{1'b0}}};
        if ({1'b0, fp_diff} >= SHIFT_LIM) begin
            aligned_mag = '0;
        end else begin
            aligned_mag = field >> fp_diff;
        end
    end

    // Lane value: signed aligned magnitude, or sign-extended integer product.
    always_comb begin
        fp_ext  = {{(SUM_W-ACC_W){1'b0}}, aligned_mag};
        int_ext = {{(SUM_W-INT_W){sig_in[INT_W-1]}}, sig_in};
        if (int_mode) begin
            lane_val = $signed(int_ext);
        end else if (neg_in) begin
            lane_val = -$signed(fp_ext);
        end else begin
            lane_val = $signed(fp_ext);
        end
    end

    // R3: a lane at least ACC_W steps below the maximum contributes nothing.
    a_r3_far_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_mode && ({1'b0, raw_diff} >= SHIFT_LIM)) |-> (lane_val == '0));

    // R3: the lane holding the maximum exponent keeps its significand unshifted.
    a_r3_top_lane_unshifted: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_mode && (raw_diff == '0)) |-> (aligned_mag[ACC_W-1 -: SIG_W] == sig_in[SIG_W-1:0]));

    // R4: a negative floating-point lane never adds a positive amount.
    a_r4_neg_lane_nonpos: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_mode && neg_in) |-> (lane_val <= 0));

    // R8: the shifter output stays zero and still across integer-mode cycles.
    a_r8_idle_in_int: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && $past(int_mode)) |-> (aligned_mag == '0 && $stable(aligned_mag)));

endmodule

// File: rtl/prod_sum_tree.sv
// Module: prod_sum_tree
// Balanced signed adder tree over N lane values of SUM_W bits.
// Assumes N is a power of two and SUM_W leaves headroom for log2(N) carries.
module prod_sum_tree #(
    parameter int N     = 4,
    parameter int SUM_W = 32
) (
    input  logic [N*SUM_W-1:0]      lane_vec,
    output logic signed [SUM_W-1:0] total
);

    localparam int NODES = 2 * N - 1;

    logic signed [SUM_W-1:0] node [NODES];

    // Adder tree: leaves hold lane values, each parent adds its two children.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            node[N-1+i] = $signed(lane_vec[i*SUM_W +: SUM_W]);
        end
        for (int k = N - 2; k >= 0; k--) begin
            node[k] = node[2*k+1] + node[2*k+2];
        end
    end

    assign total = node[0];

endmodule

// File: rtl/prod_align_add4.sv
// Module: prod_align_add4 (top)
// Aligns four products to their largest exponent and sums them, or adds four
// integer products directly in integer mode. It registers the sum, its
// exponent and a valid flag. Exponents are unsigned; integer-mode lanes are
// two's complement over the full lane width.
module prod_align_add4
    import prod_align_pkg::*;
#(
    parameter int N      = N_PROD,
    parameter int SIG_WP = SIG_W,
    parameter int EXP_WP = EXP_W,
    parameter int INT_WP = INT_W,
    parameter int ACC_WP = ACC_W,
    parameter int SUM_WP = SUM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          mode,
    input  logic [EXP_WP-1:0]   shared_exp,
    input  logic [N*INT_WP-1:0] prod_sig,
    input  logic [N*EXP_WP-1:0] prod_exp,
    input  logic [N-1:0]        prod_neg,
    output logic                out_valid,
    output logic [SUM_WP-1:0]   out_sum,
    output logic [EXP_WP-1:0]   out_exp
);

    localparam logic signed [SUM_WP-1:0] FP_BOUND = SUM_WP'(N * ((1 << ACC_WP) - 1));

    logic                     int_sel;
    logic [N*EXP_WP-1:0]      exp_iso;
    logic [EXP_WP-1:0]        emax;
    logic [N*ACC_WP-1:0]      mag_vec;
    logic [N*SUM_WP-1:0]      lane_vec;
    logic signed [SUM_WP-1:0] total;

    assign int_sel = is_int_mode(mode);

    // Operand isolation for the compare tree while integer mode is active.
    always_comb begin
        exp_iso = int_sel ? '0 : prod_exp;
    end

    prod_exp_max #(
        .N     (N),
        .EXP_W (EXP_WP)
    ) u_max (
        .clk     (clk),
        .rst_n   (rst_n),
        .exp_vec (exp_iso),
        .emax    (emax)
    );

    for (genvar g = 0; g < N; g++) begin : g_lane
        prod_align_lane #(
            .SIG_W (SIG_WP),
            .EXP_W (EXP_WP),
            .INT_W (INT_WP),
            .ACC_W (ACC_WP),
            .SUM_W (SUM_WP)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .int_mode    (int_sel),
            .sig_in      (prod_sig[g*INT_WP +: INT_WP]),
            .neg_in      (prod_neg[g]),
            .exp_in      (exp_iso[g*EXP_WP +: EXP_WP]),
            .emax_in     (emax),
            .aligned_mag (mag_vec[g*ACC_WP +: ACC_WP]),
            .lane_val    (lane_vec[g*SUM_WP +: SUM_WP])
        );
    end

    prod_sum_tree #(
        .N     (N),
        .SUM_W (SUM_WP)
    ) u_tree (
        .lane_vec (lane_vec),
        .total    (total)
    );

    // Output register: capture sum and exponent on valid input, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
            out_exp   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sum <= total;
                out_exp <= int_sel ? shared_exp : emax;
            end
        end
    end

    // R1: valid follows the input one cycle later.
    a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1: outputs hold while no input is offered.
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_sum) && $stable(out_exp)));

    // R7: integer mode reports the shared exponent.
    a_r7_int_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int_sel) |=> (out_exp == $past(shared_exp)));

    // R4: a floating-point sum stays within N full-scale aligned values.
    a_r4_fp_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !int_sel) |=>
            ($signed(out_sum) <= FP_BOUND && $signed(out_sum) >= -FP_BOUND));

    // R8: the shifters stay quiet through integer-mode cycles.
    a_r8_shifters_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> (mag_vec == '0));

endmodule

// File: tb/test_prod_align_add4.sv
// Bench: behavioural reference model compared on every clock.
module test_prod_align_add4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  shared_exp = '0;
    logic [63:0] prod_sig = '0;
    logic [31:0] prod_exp = '0;
    logic [3:0]  prod_neg = '0;
    logic        out_valid;
    logic [31:0] out_sum;
    logic [7:0]  out_exp;

    int     checks = 0;
    int     failures = 0;
    bit     finished = 1'b0;

    // Model state: what the outputs must show after the next clock edge.
    bit     m_valid = 1'b0;
    longint m_sum = 0;
    int     m_exp = 0;
    string  m_tag = "R1 reset";

    always #4 clk = ~clk;

    prod_align_add4 i_prod_align_add4 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .mode       (mode),
        .shared_exp (shared_exp),
        .prod_sig   (prod_sig),
        .prod_exp   (prod_exp),
        .prod_neg   (prod_neg),
        .out_valid  (out_valid),
        .out_sum    (out_sum),
        .out_exp    (out_exp)
    );

    task automatic compare_now();
        longint act_sum;
        act_sum = longint'($signed(out_sum));
        checks++;
        if (out_valid !== m_valid || act_sum != m_sum || int'(out_exp) != m_exp) begin
            failures++;
            $display("FAIL %s: valid=%0b sum=%0d exp=%0d expected valid=%0b sum=%0d exp=%0d",
                     m_tag, out_valid, act_sum, out_exp, m_valid, m_sum, m_exp);
        end
    endtask

    // One cycle: check the current outputs, apply new inputs, advance the model.
    task automatic step(input bit v, input logic [1:0] md, input logic [7:0] se,
                        input logic [63:0] sg, input logic [31:0] ex,
                        input logic [3:0] ng, input string tag);
        int     emx;
        longint acc;
        @(negedge clk);
        compare_now();
        in_valid = v; mode = md; shared_exp = se;
        prod_sig = sg; prod_exp = ex; prod_neg = ng;
        m_valid = v;
        if (v) begin
            m_tag = tag;
            acc = 0;
            if (md == 2'b00) begin
                for (int i = 0; i < 4; i++) begin
                    acc += longint'($signed(sg[i*16 +: 16]));
                end
                m_exp = int'(se);
            end else begin
                emx = 0;
                for (int i = 0; i < 4; i++) begin
                    if (int'(ex[i*8 +: 8]) > emx) emx = int'(ex[i*8 +: 8]);
                end
                for (int i = 0; i < 4; i++) begin
                    int     d;
                    longint mag;
                    d = emx - int'(ex[i*8 +: 8]);
                    mag = longint'(sg[i*16 +: 10]) * 262144;
                    mag = (d >= 28) ? 0 : (mag >>> d);
                    acc += ng[i] ? -mag : mag;
                end
                m_exp = emx;
            end
            m_sum = acc;
        end else begin
            m_tag = {tag, " (hold)"};
        end
    endtask

    function automatic logic [63:0] sig4(input logic [15:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    function automatic logic [31:0] exp4(input logic [7:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] sg;
        logic [31:0] ex;
        // Reset with noise on the inputs but in_valid low: R1 reset state.
        repeat (3) @(negedge clk);
        prod_sig = 64'hFFFF_1234_ABCD_7777;
        @(negedge clk);
        compare_now();
        rst_n = 1'b1;
        prod_sig = '0;

        // R2 R3: equal exponents, full-scale significands.
        step(1, 2'b01, 8'h00, sig4(16'h3FF, 16'h3FF, 16'h3FF, 16'h3FF),
             exp4(8'd5, 8'd5, 8'd5, 8'd5), 4'b0000, "R2 equal exponents");
        // R3: shift of exactly 27 keeps one bit, 28 flushes to zero.
        step(1, 2'b01, 8'h00, sig4(16'h3FF, 16'h3FF, 16'h3FF, 16'h3FF),
             exp4(8'd72, 8'd73, 8'd100, 8'd100), 4'b0000, "R3 shift 27/28 edge");
        // R3: shifts that keep fraction bits.
        step(1, 2'b10, 8'h00, sig4(16'h001, 16'h155, 16'h2AA, 16'h3FF),
             exp4(8'd40, 8'd35, 8'd30, 8'd21), 4'b0000, "R3 fraction bits kept");
        // R2: largest exponent 255 against 0.
        step(1, 2'b11, 8'h00, sig4(16'h200, 16'h3FF, 16'h001, 16'h100),
             exp4(8'd0, 8'd255, 8'd0, 8'd254), 4'b0000, "R2 exponent extremes");
        // R4: mixed signs.
        step(1, 2'b01, 8'h00, sig4(16'h3FF, 16'h100, 16'h080, 16'h001),
             exp4(8'd9, 8'd9, 8'd8, 8'd3), 4'b1010, "R4 mixed signs");
        // R4: all negative full scale.
        step(1, 2'b01, 8'h00, sig4(16'h3FF, 16'h3FF, 16'h3FF, 16'h3FF),
             exp4(8'd7, 8'd7, 8'd7, 8'd7), 4'b1111, "R4 all negative");
        // R5: upper lane bits set, result equals the low-10-bit result.
        step(1, 2'b01, 8'h00, sig4(16'hFC01, 16'hA955, 16'h56AA, 16'hFFFF),
             exp4(8'd40, 8'd35, 8'd30, 8'd21), 4'b0000, "R5 upper bits ignored");
        // R6: the same vector in each floating-point mode.
        sg = sig4(16'h123, 16'h0F0, 16'h3C3, 16'h081);
        ex = exp4(8'd17, 8'd20, 8'd14, 8'd19);
        step(1, 2'b01, 8'h00, sg, ex, 4'b0100, "R6 fp mode 01");
        step(1, 2'b10, 8'h00, sg, ex, 4'b0100, "R6 fp mode 10");
        step(1, 2'b11, 8'h00, sg, ex, 4'b0100, "R6 fp mode 11");
        // R7: integer mode, most negative products, noisy exponents and signs.
        step(1, 2'b00, 8'h3C, sig4(16'h8000, 16'h8000, 16'h8000, 16'h8000),
             exp4(8'd1, 8'd200, 8'd33, 8'd99), 4'b1111, "R7 int most negative");
        step(1, 2'b00, 8'hC3, sig4(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF),
             exp4(8'd250, 8'd0, 8'd7, 8'd128), 4'b0101, "R7 int most positive");
        // R8: integer-mode result unaffected while the exponents churn.
        for (int k = 0; k < 6; k++) begin
            step(1, 2'b00, 8'(k), sig4(16'h1234, 16'hFEDC, 16'h0001, 16'h8001),
                 $urandom(), 4'($urandom()), "R8 int mode with exponent noise");
        end
        // R1: input valid low holds the outputs while inputs change.
        for (int k = 0; k < 3; k++) begin
            step(0, 2'($urandom()), 8'($urandom()), {$urandom(), $urandom()},
                 $urandom(), 4'($urandom()), "R1 hold");
        end
        // R6 R8: back to a floating-point mode right after integer mode.
        step(1, 2'b00, 8'h11, sig4(16'h0100, 16'h0200, 16'h0300, 16'h0400),
             exp4(8'd3, 8'd4, 8'd5, 8'd6), 4'b0000, "R8 int before switch");
        step(1, 2'b10, 8'h11, sig4(16'h0100, 16'h0200, 16'h0300, 16'h0400),
             exp4(8'd3, 8'd4, 8'd5, 8'd6), 4'b0000, "R6 fp after switch");
        // R3 R4: random products with clustered exponents, random modes and valid.
        for (int k = 0; k < 3000; k++) begin
            int base;
            base = $urandom_range(0, 224);
            ex = exp4(8'(base + $urandom_range(0, 31)), 8'(base + $urandom_range(0, 31)),
                      8'(base + $urandom_range(0, 31)), 8'(base + $urandom_range(0, 31)));
            step(($urandom_range(0, 7) != 0), 2'($urandom()), 8'($urandom()),
                 {$urandom(), $urandom()}, ex, 4'($urandom()), "R3 R4 random");
        end
        @(negedge clk);
        compare_now();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule